// File: doc/BRIEF.md
# Parallel-Bus Converter Sample Sequencer

This block is the host-side controller for a 16-bit successive-approximation converter that has a byte-wide parallel data bus. It runs the converter's three-edge chip-select protocol to take one sample for each request. The first falling edge starts acquisition. The second starts the conversion, and the level of the read/convert line at that edge picks either reference standby or reference shutdown for after the conversion. The third edge, made with read/convert high, reads the result out. The block collects the two bytes by steering the high-byte select line, joins them into one word, and marks that word with a single-cycle valid pulse. Every analog-side timing is a parameter counted in clock cycles.

The sequencer remembers whether the converter's reference was left switched off. After reset, or after a sample taken in shutdown mode, it stretches the acquisition phase to the reference wake-up time. The end-of-conversion input is synchronized on entry. If that line never falls, a timeout ends the wait, raises an error flag and still runs the read.

The state machine has eight states. `S_IDLE` moves to `S_ACQ_LO` on an accepted request. `S_ACQ_LO` (first edge, chip select low) moves to `S_ACQ_HI` (acquisition window). `S_ACQ_HI` moves to `S_CNV_LO` (second edge). `S_CNV_LO` moves to `S_CNV_WT` (waiting for end of conversion). `S_CNV_WT` moves to `S_RD_HI` (third edge, high byte selected). `S_RD_HI` moves to `S_RD_LO` (low byte selected). `S_RD_LO` moves to `S_RELQ` (bus relinquish gap). `S_RELQ` returns to `S_IDLE`. Every state except `S_IDLE` and `S_CNV_WT` leaves when its cycle count expires. `S_CNV_WT` leaves on end of conversion or on timeout.

Top module: `pbus_sample_ctrl`

## Requirements
- R1: During and straight after reset, cs_n_o is 1, rc_o is 0, hben_o is 1, and busy_o, valid_o and eoc_err_o are 0.
- R2: When start_i is sampled high in S_IDLE, the next cycle drives cs_n_o low with rc_o low. Chip select then stays low for CS_LO_CYC cycles.
- R3: When the reference was left on (the previous sample was in standby mode), chip select stays high for max(ACQ_CYC, CS_HI_CYC) cycles before the conversion edge. During that window rc_o carries the shutdown choice that was captured with the request.
- R4: After reset, and after any sample taken with shutdown selected, the acquisition high phase lasts max(WAKE_CYC, CS_HI_CYC) cycles instead.
- R5: The conversion-start edge holds cs_n_o low for CS_LO_CYC cycles, with rc_o equal to the captured shdn_cfg_i (1 means shutdown, 0 means standby). rc_o is unchanged in every cycle where cs_n_o falls.
- R6: After the conversion edge, chip select is high with rc_o at 1. The read edge follows once the end-of-conversion input, after a two-flop synchronizer, is seen low and chip select has been high for at least CS_HI_CYC cycles.
- R7: If end of conversion has not been seen low after TOUT_CYC cycles of waiting, the read starts anyway and eoc_err_o rises. eoc_err_o stays high until the next request is accepted.
- R8: The read holds cs_n_o low for DO_CYC cycles with hben_o at 1, then for DO_CYC cycles with hben_o at 0. data_i is sampled on the last cycle of each half. hben_o is 0 only while chip select is low.
- R9: result_o is {high byte, low byte}, updated in the first cycle after chip select rises from the read. valid_o is high for exactly that one cycle.
- R10: After the read, chip select stays high for max(RELQ_CYC, CS_HI_CYC) cycles before busy_o falls. busy_o is high from the cycle after acceptance to the end of that gap.
- R11: start_i has no effect while busy_o is high. Outputs follow the cycle already under way, and no second sample begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Sample request, sampled in idle |
| shdn_cfg_i | input | 1 | 1 = power reference down after this sample, 0 = keep it on |
| eoc_n_i | input | 1 | Converter end-of-conversion, falls when data is ready (asynchronous) |
| data_i | input | 8 | Converter byte bus |
| cs_n_o | output | 1 | Chip select to converter, active low |
| rc_o | output | 1 | Read/convert level to converter |
| hben_o | output | 1 | High-byte select, 1 = upper byte on the bus |
| busy_o | output | 1 | A sample cycle is in progress |
| result_o | output | 16 | Last assembled sample |
| valid_o | output | 1 | One-cycle strobe marking a new result |
| eoc_err_o | output | 1 | End-of-conversion timeout flag |

## Verification
All outputs are registered from the next state, so each pin changes in the cycle after the edge where its phase counter expires. valid_o and result_o appear one cycle after the low byte is sampled. End of conversion takes effect two cycles after the pin falls, because of the synchronizer, and eoc_err_o shows one cycle after the timeout edge. The bench model advances on the same edges using its own phase numbers and elapsed-cycle counts, and it copies the synchronizer delay with a two-entry history. Every output is compared at the falling clock edge, so each expected value is checked in exactly the cycle it is due.

// File: rtl/pbus_sample_pkg.sv
package pbus_sample_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_ACQ_LO,
        S_ACQ_HI,
        S_CNV_LO,
        S_CNV_WT,
        S_RD_HI,
        S_RD_LO,
        S_RELQ
    } seq_state_e;

    function automatic int unsigned imax(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/psc_sync.sv
module psc_sync #(
    parameter int unsigned STAGES  = 2,
    parameter logic        RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= {STAGES{RST_VAL}};
        else        chain_q <= {chain_q[STAGES-2:0], d_i};
    end

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/psc_timer.sv
module psc_timer #(
    parameter int unsigned CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_i,
    output logic [CW-1:0] cnt_o
);
    localparam logic [CW-1:0] TOP = {CW{1'b1}};

    always_ff @(posedge clk) begin
        if (!rst_n || clr_i)  cnt_o <= '0;
        else if (cnt_o != TOP) cnt_o <= cnt_o + 1'b1;
    end

    p_sat_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && cnt_o == TOP) |=> (cnt_o == TOP));
endmodule

// File: rtl/psc_join.sv
module psc_join #(
    parameter int unsigned BYTE_W = 8,
    localparam int unsigned WORD_W = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_hi_i,
    input  logic              cap_lo_i,
    input  logic [BYTE_W-1:0] byte_i,
    output logic [WORD_W-1:0] word_o,
    output logic              valid_o
);
    logic [BYTE_W-1:0] hi_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_q    <= '0;
            word_o  <= '0;
            valid_o <= 1'b0;
        end else begin
            valid_o <= cap_lo_i;
            if (cap_hi_i) hi_q   <= byte_i;
            if (cap_lo_i) word_o <= {hi_q, byte_i};
        end
    end

    p_valid_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);
endmodule

// File: rtl/psc_fsm.sv
module psc_fsm
    import pbus_sample_pkg::*;
#(
    parameter int unsigned CS_LO_CYC = 8,
    parameter int unsigned CS_HI_CYC = 6,
    parameter int unsigned ACQ_CYC   = 200,
    parameter int unsigned WAKE_CYC  = 1200000,
    parameter int unsigned TOUT_CYC  = 500,
    parameter int unsigned DO_CYC    = 8,
    parameter int unsigned RELQ_CYC  = 8,
    parameter int unsigned CW        = 21
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          shdn_i,
    input  logic          eoc_s_i,
    input  logic [CW-1:0] cnt_i,
    output logic          clr_o,
    output logic          cap_hi_o,
    output logic          cap_lo_o,
    output logic          cs_n_o,
    output logic          rc_o,
    output logic          hben_o,
    output logic          busy_o,
    output logic          err_o
);
    localparam logic [CW-1:0] L_CSLO = CW'(CS_LO_CYC - 1);
    localparam logic [CW-1:0] L_CSHI = CW'(CS_HI_CYC - 1);
    localparam logic [CW-1:0] L_ACQ  = CW'(imax(ACQ_CYC, CS_HI_CYC) - 1);
    localparam logic [CW-1:0] L_WAKE = CW'(imax(WAKE_CYC, CS_HI_CYC) - 1);
    localparam logic [CW-1:0] L_TOUT = CW'(TOUT_CYC - 1);
    localparam logic [CW-1:0] L_DO   = CW'(DO_CYC - 1);
    localparam logic [CW-1:0] L_RELQ = CW'(imax(RELQ_CYC, CS_HI_CYC) - 1);

    seq_state_e state_q, state_d;
    logic       sd_q;
    logic       ref_off_q;
    logic       eoc_seen;
    logic       tout_hit;

    assign eoc_seen = !eoc_s_i && (cnt_i >= L_CSHI);
    assign tout_hit = cnt_i >= L_TOUT;

    always_comb begin
        state_d  = state_q;
        cap_hi_o = 1'b0;
        cap_lo_o = 1'b0;
        unique case (state_q)
            S_IDLE:   if (start_i) state_d = S_ACQ_LO;
            S_ACQ_LO: if (cnt_i >= L_CSLO) state_d = S_ACQ_HI;
            S_ACQ_HI: if (cnt_i >= (ref_off_q ? L_WAKE : L_ACQ)) state_d = S_CNV_LO;
            S_CNV_LO: if (cnt_i >= L_CSLO) state_d = S_CNV_WT;
            S_CNV_WT: if (eoc_seen || tout_hit) state_d = S_RD_HI;
            S_RD_HI: begin
                if (cnt_i >= L_DO) begin
                    state_d  = S_RD_LO;
                    cap_hi_o = 1'b1;
                end
            end
            S_RD_LO: begin
                if (cnt_i >= L_DO) begin
                    state_d  = S_RELQ;
                    cap_lo_o = 1'b1;
                end
            end
            S_RELQ:   if (cnt_i >= L_RELQ) state_d = S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    assign clr_o = (state_d != state_q);

    // state register and per-sample context
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= S_IDLE;
            sd_q      <= 1'b0;
            ref_off_q <= 1'b1;
            err_o     <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == S_IDLE && start_i) begin
                sd_q  <= shdn_i;
                err_o <= 1'b0;
            end
            if (state_q == S_CNV_WT && !eoc_seen && tout_hit) err_o <= 1'b1;
            if (state_q == S_RELQ && state_d == S_IDLE) ref_off_q <= sd_q;
        end
    end

    // registered pin levels decoded from the next state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_n_o <= 1'b1;
            rc_o   <= 1'b0;
            hben_o <= 1'b1;
            busy_o <= 1'b0;
        end else begin
            cs_n_o <= !(state_d inside {S_ACQ_LO, S_CNV_LO, S_RD_HI, S_RD_LO});
            hben_o <= (state_d != S_RD_LO);
            busy_o <= (state_d != S_IDLE);
            unique case (state_d)
                S_ACQ_HI, S_CNV_LO:         rc_o <= sd_q;
                S_CNV_WT, S_RD_HI, S_RD_LO: rc_o <= 1'b1;
                default:                    rc_o <= 1'b0;
            endcase
        end
    end

    p_rc_setup_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n_o) |-> $stable(rc_o));
    p_hben_in_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !hben_o |-> !cs_n_o);
    p_busy_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && state_q != S_RELQ) |=> busy_o);
    p_err_on_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_o) |-> (state_q == S_RD_HI));
endmodule

// File: rtl/pbus_sample_ctrl.sv
module pbus_sample_ctrl
    import pbus_sample_pkg::*;
#(
    parameter int unsigned BYTE_W    = 8,
    parameter int unsigned CS_LO_CYC = 8,
    parameter int unsigned CS_HI_CYC = 6,
    parameter int unsigned ACQ_CYC   = 200,
    parameter int unsigned WAKE_CYC  = 1200000,
    parameter int unsigned TOUT_CYC  = 500,
    parameter int unsigned DO_CYC    = 8,
    parameter int unsigned RELQ_CYC  = 8,
    parameter int unsigned SYNC_STG  = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic                shdn_cfg_i,
    input  logic                eoc_n_i,
    input  logic [BYTE_W-1:0]   data_i,
    output logic                cs_n_o,
    output logic                rc_o,
    output logic                hben_o,
    output logic                busy_o,
    output logic [2*BYTE_W-1:0] result_o,
    output logic                valid_o,
    output logic                eoc_err_o
);
    localparam int unsigned MAXV = imax(imax(imax(CS_LO_CYC, CS_HI_CYC), imax(ACQ_CYC, WAKE_CYC)),
                                        imax(imax(TOUT_CYC, DO_CYC), RELQ_CYC));
    localparam int unsigned CW   = $clog2(MAXV + 1);

    logic          eoc_s;
    logic          clr;
    logic          cap_hi, cap_lo;
    logic [CW-1:0] cnt;

    psc_sync #(.STAGES(SYNC_STG), .RST_VAL(1'b1)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_i(eoc_n_i), .q_o(eoc_s)
    );

    psc_timer #(.CW(CW)) u_timer (
        .clk(clk), .rst_n(rst_n), .clr_i(clr), .cnt_o(cnt)
    );

    psc_fsm #(
        .CS_LO_CYC(CS_LO_CYC), .CS_HI_CYC(CS_HI_CYC), .ACQ_CYC(ACQ_CYC),
        .WAKE_CYC(WAKE_CYC), .TOUT_CYC(TOUT_CYC), .DO_CYC(DO_CYC),
        .RELQ_CYC(RELQ_CYC), .CW(CW)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .shdn_i(shdn_cfg_i),
        .eoc_s_i(eoc_s), .cnt_i(cnt), .clr_o(clr), .cap_hi_o(cap_hi),
        .cap_lo_o(cap_lo), .cs_n_o(cs_n_o), .rc_o(rc_o), .hben_o(hben_o),
        .busy_o(busy_o), .err_o(eoc_err_o)
    );

    psc_join #(.BYTE_W(BYTE_W)) u_join (
        .clk(clk), .rst_n(rst_n), .cap_hi_i(cap_hi), .cap_lo_i(cap_lo),
        .byte_i(data_i), .word_o(result_o), .valid_o(valid_o)
    );

    p_valid_after_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (cs_n_o && $past(!cs_n_o)));
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (cs_n_o && hben_o));
endmodule

// File: tb/pbus_sample_ctrl_bench.sv
module pbus_sample_ctrl_bench;
    localparam int CSLO = 2, CSHI = 3, ACQ = 6, WAKE = 40, TOUT = 30, DOC = 3, RELQ = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        shdn = 1'b0;
    logic        eoc_n = 1'b1;
    logic [7:0]  conv_hi = 8'h00, conv_lo = 8'h00;
    logic [7:0]  data;
    logic        cs_n, rc, hben, busy, valid, err;
    logic [15:0] result;

    always #5 clk = ~clk;

    assign data = hben ? conv_hi : conv_lo;

    pbus_sample_ctrl #(
        .CS_LO_CYC(CSLO), .CS_HI_CYC(CSHI), .ACQ_CYC(ACQ), .WAKE_CYC(WAKE),
        .TOUT_CYC(TOUT), .DO_CYC(DOC), .RELQ_CYC(RELQ)
    ) u_pbus_sample_ctrl (
        .clk(clk), .rst_n(rst_n), .start_i(start), .shdn_cfg_i(shdn),
        .eoc_n_i(eoc_n), .data_i(data), .cs_n_o(cs_n), .rc_o(rc),
        .hben_o(hben), .busy_o(busy), .result_o(result), .valid_o(valid),
        .eoc_err_o(err)
    );

    int n_chk = 0, n_err = 0;

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // behavioural model: phase 0 idle .. 7 relinquish gap
    int ph = 0, el = 0, sd = 0, refoff = 1, merr = 0, mval = 0, mres = 0, e1 = 1, e2 = 1;

    function automatic int mx(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            ph = 0; el = 0; refoff = 1; merr = 0; mval = 0; mres = 0; e1 = 1; e2 = 1;
        end else begin
            int nph;
            nph = ph;
            mval = 0;
            case (ph)
                0: if (start) begin nph = 1; sd = shdn; merr = 0; end
                1: if (el == CSLO - 1) nph = 2;
                2: if (el == (refoff ? mx(WAKE, CSHI) : mx(ACQ, CSHI)) - 1) nph = 3;
                3: if (el == CSLO - 1) nph = 4;
                4: begin
                    if (e2 == 0 && el >= CSHI - 1) nph = 5;
                    else if (el >= TOUT - 1) begin nph = 5; merr = 1; end
                end
                5: if (el == DOC - 1) nph = 6;
                6: if (el == DOC - 1) begin nph = 7; mval = 1; mres = {conv_hi, conv_lo}; end
                7: if (el == mx(RELQ, CSHI) - 1) begin nph = 0; refoff = sd; end
                default: nph = 0;
            endcase
            el = (nph != ph) ? 0 : el + 1;
            ph = nph;
            e2 = e1; e1 = eoc_n;
        end
    end

    function automatic string ph_tag(input int p);
        case (p)
            1: return "R2";
            2: return refoff_tag();
            3: return "R5";
            4: return "R6";
            5, 6: return "R8";
            7: return "R10";
            default: return "R11";
        endcase
    endfunction

    function automatic string refoff_tag();
        return "R3/R4";
    endfunction

    always @(negedge clk) begin
        if (rst_n) begin
            int ecs, erc, ehb;
            ecs = (ph == 1 || ph == 3 || ph == 5 || ph == 6) ? 0 : 1;
            erc = (ph == 2 || ph == 3) ? sd : ((ph >= 4 && ph <= 6) ? 1 : 0);
            ehb = (ph == 6) ? 0 : 1;
            check(cs_n === 1'(ecs), ph_tag(ph), "cs_n", cs_n, ecs);
            check(rc === 1'(erc), ph_tag(ph), "rc", rc, erc);
            check(hben === 1'(ehb), "R8", "hben", hben, ehb);
            check(busy === (ph != 0), "R10", "busy", busy, ph != 0);
            check(valid === 1'(mval), "R9", "valid", valid, mval);
            if (mval) check(result === 16'(mres), "R9", "result", result, mres);
            check(err === 1'(merr), "R7", "eoc_err", err, merr);
        end
    end

    // converter stand-in: counts chip-select falls and drops end of conversion
    int falls = 0, eoc_dly = 5, eoc_cnt = -1;
    logic prev_cs = 1'b1;
    always @(negedge clk) begin
        if (prev_cs && !cs_n) begin
            falls++;
            if (falls == 2) eoc_cnt = eoc_dly;
            if (falls == 3) begin eoc_n <= 1'b1; eoc_cnt = -1; end
        end
        if (eoc_cnt == 0) begin eoc_n <= 1'b0; eoc_cnt = -1; end
        else if (eoc_cnt > 0) eoc_cnt--;
        if (!busy) falls = 0;
        prev_cs = cs_n;
    end

    task automatic sample(input bit sdv, input int dly, input logic [7:0] h, input logic [7:0] l,
                          input bit poke);
        @(negedge clk);
        shdn = sdv; eoc_dly = dly; conv_hi = h; conv_lo = l; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            // R11: extra requests while busy must change nothing
            repeat (4) @(negedge clk);
            start = 1'b1; shdn = ~sdv;
            repeat (3) @(negedge clk);
            start = 1'b0;
        end
        while (busy) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    int wd = 0;
    always @(posedge clk) begin
        wd++;
        if (wd > 100000) begin
            n_chk++; n_err++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset values
        check(cs_n === 1'b1 && rc === 1'b0 && hben === 1'b1, "R1", "pins in reset",
              {cs_n, rc, hben}, 3'b101);
        check(busy === 1'b0 && valid === 1'b0 && err === 1'b0, "R1", "flags in reset",
              {busy, valid, err}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(cs_n === 1'b1 && busy === 1'b0, "R1", "after reset", {cs_n, busy}, 2'b10);
        sample(1'b0, 6,  8'hA5, 8'h3C, 1'b0);  // R4 wake after reset, standby chosen
        sample(1'b0, 9,  8'h12, 8'hEF, 1'b1);  // R3 short acquisition, R11 pokes
        sample(1'b1, 4,  8'hFF, 8'h00, 1'b0);  // shutdown chosen
        sample(1'b0, 0,  8'h00, 8'hFF, 1'b0);  // R4 wake again; R6 early end of conversion
        sample(1'b0, -1, 8'h5A, 8'hC3, 1'b0);  // R7 timeout
        check(err === 1'b1, "R7", "flag held in idle", err, 1);
        sample(1'b1, 12, 8'h80, 8'h01, 1'b1);  // R7 flag cleared on accept
        sample(1'b0, 2,  8'h7E, 8'h81, 1'b0);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule